// File: doc/BRIEF.md
# Shifted-Operand Data-Processing Unit

This block is the combinational heart of an execute stage. It receives an operation code, a first operand taken from the register file, and a second operand. The second operand is either a register value or an 8-bit constant packed with a rotation field. The second operand is always routed through a barrel shifter before the arithmetic/logic stage sees it. The block returns a data result and a destination write-enable. It also returns the N, Z, C and V flags, either freshly computed or carried through unchanged.

A register second operand is shifted by one of four shift kinds. The amount comes either from a 5-bit field of the instruction or from the low byte of a third register. Sixteen operations cover add/subtract with and without carry, reverse subtract, bitwise logic, moves, and four flag-only comparisons. The comparisons never request a register write. Condition evaluation, the register file and decode all sit outside the block.

Top module: `dp_exec_unit`

## Requirements
- R1: Arithmetic codes 6 ADD (a+b), 7 ADC (a+b+C), 8 SUB (a-b), 9 SBC (a-b-!C), 10 RSB (b-a), 11 RSC (b-a-!C) give the 32-bit result, where a is `rn_val`, b is the shifted second operand, and C is `flags_in[1]`.
- R2: Logic codes 2 AND, 3 OR, 4 XOR and 5 BIC (a AND NOT b) give the bitwise result of a and b.
- R3: Code 0 (move) returns b and code 1 (move-inverted) returns NOT b; `rn_val` has no effect on either.
- R4: Codes 12 CMP (a-b), 13 CMN (a+b), 14 TST (a AND b) and 15 TEQ (a XOR b) hold `rd_we` low and always update the flags; every other code drives `rd_we` high.
- R5: Flags are bit 3 N, bit 2 Z, bit 1 C, bit 0 V of `flags_in`/`flags_out`. Outside codes 12 to 15, new flags appear only when `set_flags` is 1; otherwise `flags_out` equals `flags_in`.
- R6: With `use_imm` high, b is `imm8` zero-extended and rotated right by 2*`imm_rot`. The shifter carry is `flags_in[1]` when that rotation is 0, and bit 31 of b otherwise.
- R7: `shift_kind` selects 0 LSL, 1 LSR, 2 ASR or 3 ROR. With `shift_by_reg` low, the amount is `shift_imm`; the shifter carry is the last bit shifted out.
- R8: With `shift_by_reg` high, the amount is `rs_val[7:0]`. For LSL or LSR, an amount of 32 gives 0 with carry bit 0 (LSL) or bit 31 (LSR), and above 32 gives 0 with carry 0. ASR of 32 or more fills with bit 31 and carries bit 31. ROR uses the amount mod 32, and a nonzero multiple of 32 keeps the value and carries bit 31.
- R9: A shift amount of zero leaves the operand unchanged and the shifter carry equals `flags_in[1]`.
- R10: For logic, move and TST/TEQ codes, updated flags take N and Z from the result, C from the shifter carry, and V unchanged from `flags_in[0]`.
- R11: For arithmetic and CMP/CMN codes, updated C is the adder carry-out (1 = no borrow on subtraction), and V is signed two's-complement overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code (see R1 to R4) |
| set_flags | input | 1 | Request flag update for non-compare codes |
| rn_val | input | 32 | First operand register value |
| use_imm | input | 1 | Second operand is the rotated constant |
| imm8 | input | 8 | Constant byte |
| imm_rot | input | 4 | Constant rotation, in units of two bits |
| rm_val | input | 32 | Register second operand |
| shift_kind | input | 2 | Shift type for a register second operand |
| shift_by_reg | input | 1 | Take the shift amount from `rs_val[7:0]` |
| shift_imm | input | 5 | Immediate shift amount |
| rs_val | input | 32 | Register holding a shift amount in its low byte |
| flags_in | input | 4 | Current N, Z, C, V |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next N, Z, C, V |

## Verification
The block holds no state, so any internal fault shows at the ports for the very vector that exposes it, and for no other vector. A faulty shifter path shows up two ways: as a wrong `result` on move codes, and as a wrong C in `flags_out` on logic codes. The vectors with zero, 32 and over-32 amounts catch faults in the edge handling. A wrong adder operand inversion or carry-in shows as a wrong result or a wrong C/V on the subtract and reverse-subtract codes. A wrong flag-enable decode shows as flags that move when `set_flags` is low, or as `rd_we` set on a comparison.

// File: rtl/dp_pkg.sv
// Package: shared encodings for the shifted-operand execute unit.
// Assumes a 4-bit operation code and a 2-bit shift kind as listed in the brief.
package dp_pkg;

    localparam int IMM_W = 8;   // constant byte width
    localparam int ROT_W = 4;   // rotation field width
    localparam int AMT_W = 8;   // shift amount width (low byte of a register)

    typedef enum logic [3:0] {
        OP_MOVE = 4'd0,
        OP_MOVN = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_BIC  = 4'd5,
        OP_ADD  = 4'd6,
        OP_ADC  = 4'd7,
        OP_SUB  = 4'd8,
        OP_SBC  = 4'd9,
        OP_RSB  = 4'd10,
        OP_RSC  = 4'd11,
        OP_CMP  = 4'd12,
        OP_CMN  = 4'd13,
        OP_TST  = 4'd14,
        OP_TEQ  = 4'd15
    } dp_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } dp_shift_e;

    // flag bit positions inside the 4-bit flag vector
    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_C = 1;
    localparam int FL_V = 0;

endpackage

// File: rtl/dp_shifter.sv
// Module: barrel shifter for the second operand.
// Shifts by an 8-bit amount with LSL/LSR/ASR/ROR and produces a carry-out.
// Assumes DW is a power of two and below 256. Purely combinational.
module dp_shifter
    import dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]    x,
    input  dp_shift_e        kind,
    input  logic [AMT_W-1:0] amt,
    input  logic             cin,
    output logic [DW-1:0]    res,
    output logic             cout
);
    localparam int AW = $clog2(DW);

    logic [2*DW-1:0] wide;
    logic [AW-1:0]   sh;

    // Shift the operand and pick the bit last shifted out.
    always_comb begin
        wide = '0;
        sh   = amt[AW-1:0];
        res  = x;
        cout = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    if (int'(amt) < DW) begin
                        wide = {{DW{1'b0}}, x} << sh;
                        res  = wide[DW-1:0];
                        cout = wide[DW];
                    end else begin
                        res  = '0;
                        cout = (int'(amt) == DW) ? x[0] : 1'b0;
                    end
                end
                SH_LSR: begin
                    if (int'(amt) < DW) begin
                        wide = {x, {DW{1'b0}}} >> sh;
                        res  = wide[2*DW-1:DW];
                        cout = wide[DW-1];
                    end else begin
                        res  = '0;
                        cout = (int'(amt) == DW) ? x[DW-1] : 1'b0;
                    end
                end
                SH_ASR: begin
                    if (int'(amt) < DW) begin
                        wide = $signed({x, {DW{1'b0}}}) >>> sh;
                        res  = wide[2*DW-1:DW];
                        cout = wide[DW-1];
                    end else begin
                        res  = {DW{x[DW-1]}};
                        cout = x[DW-1];
                    end
                end
                default: begin
                    if (sh == '0) begin
                        res  = x;
                        cout = x[DW-1];
                    end else begin
                        res  = (x >> sh) | (x << (DW - int'(sh)));
                        cout = res[DW-1];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module: adder, bitwise logic and flag generation for the execute unit.
// Takes the first operand and the already-shifted second operand.
// Assumes the shifter carry is valid for the same vector. Combinational.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  dp_op_e        op,
    input  logic          set_flags,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sh_carry,
    input  logic [3:0]    flags_in,
    output logic [DW-1:0] result,
    output logic          rd_we,
    output logic [3:0]    flags_out
);
    logic [DW-1:0] add_x, add_y;
    logic          add_ci;
    logic [DW:0]   sum;
    logic          add_v;
    logic          is_arith;
    logic          is_cmp;
    logic          upd;
    logic [3:0]    fresh;

    // Choose adder operand inversion and carry-in per operation.
    always_comb begin
        add_x    = a;
        add_y    = b;
        add_ci   = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_ADD, OP_CMN: ;
            OP_ADC:         add_ci = flags_in[FL_C];
            OP_SUB, OP_CMP: begin add_y = ~b; add_ci = 1'b1; end
            OP_SBC:         begin add_y = ~b; add_ci = flags_in[FL_C]; end
            OP_RSB:         begin add_x = ~a; add_ci = 1'b1; end
            OP_RSC:         begin add_x = ~a; add_ci = flags_in[FL_C]; end
            default:        is_arith = 1'b0;
        endcase
    end

    // Single shared adder with signed overflow detection.
    always_comb begin
        sum   = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_ci};
        add_v = (add_x[DW-1] == add_y[DW-1]) && (sum[DW-1] != add_x[DW-1]);
    end

    // Select the data result.
    always_comb begin
        unique case (op)
            OP_MOVE:        result = b;
            OP_MOVN:        result = ~b;
            OP_AND, OP_TST: result = a & b;
            OP_OR:          result = a | b;
            OP_XOR, OP_TEQ: result = a ^ b;
            OP_BIC:         result = a & ~b;
            default:        result = sum[DW-1:0];
        endcase
    end

    // Write-enable and flag update decision.
    always_comb begin
        is_cmp          = (op[3:2] == 2'b11);
        rd_we           = !is_cmp;
        upd             = set_flags || is_cmp;
        fresh[FL_N]     = result[DW-1];
        fresh[FL_Z]     = (result == '0);
        fresh[FL_C]     = is_arith ? sum[DW] : sh_carry;
        fresh[FL_V]     = is_arith ? add_v : flags_in[FL_V];
        flags_out       = upd ? fresh : flags_in;
    end

endmodule

// File: rtl/dp_exec_unit.sv
// Module: top of the shifted-operand execute unit.
// Builds the second operand (rotated constant or shifted register), then
// runs it through the ALU. No clock: the unit is a pure combinational cone.
module dp_exec_unit
    import dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]       op_code,
    input  logic             set_flags,
    input  logic [DW-1:0]    rn_val,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm8,
    input  logic [ROT_W-1:0] imm_rot,
    input  logic [DW-1:0]    rm_val,
    input  logic [1:0]       shift_kind,
    input  logic             shift_by_reg,
    input  logic [4:0]       shift_imm,
    input  logic [DW-1:0]    rs_val,
    input  logic [3:0]       flags_in,
    output logic [DW-1:0]    result,
    output logic             rd_we,
    output logic [3:0]       flags_out
);
    localparam int PAD_W = AMT_W - ROT_W - 1;
    localparam int IPAD  = AMT_W - 5;

    logic [DW-1:0]    sh_in;
    dp_shift_e        sh_kind;
    logic [AMT_W-1:0] sh_amt;
    logic [DW-1:0]    op_b;
    logic             op_b_c;

    // Route either the constant or the register into the shifter.
    always_comb begin
        if (use_imm) begin
            sh_in   = {{(DW-IMM_W){1'b0}}, imm8};
            sh_kind = SH_ROR;
            sh_amt  = {{PAD_W{1'b0}}, imm_rot, 1'b0};
        end else begin
            sh_in   = rm_val;
            sh_kind = dp_shift_e'(shift_kind);
            sh_amt  = shift_by_reg ? rs_val[AMT_W-1:0] : {{IPAD{1'b0}}, shift_imm};
        end
    end

    dp_shifter #(.DW(DW)) u_shifter (
        .x    (sh_in),
        .kind (sh_kind),
        .amt  (sh_amt),
        .cin  (flags_in[FL_C]),
        .res  (op_b),
        .cout (op_b_c)
    );

    dp_alu #(.DW(DW)) u_alu (
        .op        (dp_op_e'(op_code)),
        .set_flags (set_flags),
        .a         (rn_val),
        .b         (op_b),
        .sh_carry  (op_b_c),
        .flags_in  (flags_in),
        .result    (result),
        .rd_we     (rd_we),
        .flags_out (flags_out)
    );

endmodule

// File: rtl/dp_exec_unit_chk.sv
// Module: property checker for dp_exec_unit, bound onto every instance.
// Uses immediate assertions because the unit has no clock.
module dp_exec_unit_chk #(
    parameter int DW = 32
) (
    input logic [3:0]    op_code,
    input logic          set_flags,
    input logic [DW-1:0] rn_val,
    input logic          use_imm,
    input logic [7:0]    imm8,
    input logic [3:0]    imm_rot,
    input logic [DW-1:0] rm_val,
    input logic [1:0]    shift_kind,
    input logic          shift_by_reg,
    input logic [4:0]    shift_imm,
    input logic [DW-1:0] rs_val,
    input logic [3:0]    flags_in,
    input logic [DW-1:0] result,
    input logic          rd_we,
    input logic [3:0]    flags_out
);
    // Check port-level relations for every settled input vector.
    always_comb begin
        if (op_code[3:2] == 2'b11) begin
            assert_cmp_no_write_R4: assert (!rd_we)
                else $error("compare code wrote destination");
        end else begin
            assert_op_writes_R4: assert (rd_we)
                else $error("data code did not write destination");
        end
        if (!set_flags && op_code[3:2] != 2'b11) begin
            assert_flags_held_R5: assert (flags_out == flags_in)
                else $error("flags changed without request");
        end
        if ((op_code <= 4'd5 || op_code >= 4'd14) && (set_flags || op_code[3:2] == 2'b11)) begin
            assert_logic_keeps_v_R10: assert (flags_out[0] == flags_in[0])
                else $error("logic code altered V");
        end
        if (op_code == 4'd0 && use_imm && imm_rot == 4'd0) begin
            assert_imm_norot_R6: assert (result == {{(DW-8){1'b0}}, imm8})
                else $error("unrotated constant altered");
        end
        if (op_code == 4'd0 && !use_imm && shift_by_reg && rs_val[7:0] == 8'd0) begin
            assert_zero_amt_pass_R9: assert (result == rm_val)
                else $error("zero register shift altered operand");
        end
    end
endmodule

bind dp_exec_unit dp_exec_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/dp_exec_unit_bench.sv
// Bench: scoreboard for dp_exec_unit. A driver applies a vector on the
// falling edge and queues the model's expectation; a monitor pops and
// compares on the next rising edge.
module dp_exec_unit_bench;

    typedef struct {
        logic [3:0]  op;
        logic        sf;
        logic [31:0] rn;
        logic        ui;
        logic [7:0]  i8;
        logic [3:0]  rot;
        logic [31:0] rm;
        logic [1:0]  sk;
        logic        sbr;
        logic [4:0]  si;
        logic [31:0] rs;
        logic [3:0]  fin;
    } stim_t;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    exp_t        sb_q[$];

    logic [3:0]  op_code;
    logic        set_flags;
    logic [31:0] rn_val;
    logic        use_imm;
    logic [7:0]  imm8;
    logic [3:0]  imm_rot;
    logic [31:0] rm_val;
    logic [1:0]  shift_kind;
    logic        shift_by_reg;
    logic [4:0]  shift_imm;
    logic [31:0] rs_val;
    logic [3:0]  flags_in;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_out;

    always #2 clk = ~clk;

    dp_exec_unit u_dp_exec_unit (
        .op_code(op_code), .set_flags(set_flags), .rn_val(rn_val),
        .use_imm(use_imm), .imm8(imm8), .imm_rot(imm_rot), .rm_val(rm_val),
        .shift_kind(shift_kind), .shift_by_reg(shift_by_reg),
        .shift_imm(shift_imm), .rs_val(rs_val), .flags_in(flags_in),
        .result(result), .rd_we(rd_we), .flags_out(flags_out)
    );

    // Reference shifter: one bit per step, carry tracks the bit pushed out.
    function automatic void ref_shift(input logic [31:0] x, input logic [1:0] k,
                                      input logic [7:0] amt, input logic cin,
                                      output logic [31:0] r, output logic c);
        r = x;
        c = cin;
        for (int i = 0; i < int'(amt); i++) begin
            case (k)
                2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endfunction

    function automatic void ref_add(input logic [31:0] x, input logic [31:0] y,
                                    input logic ci, output logic [31:0] r,
                                    output logic c, output logic v);
        longint u, s;
        u = longint'(x) + longint'(y) + longint'(ci);
        s = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
        r = u[31:0];
        c = u[32];
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic void ref_sub(input logic [31:0] x, input logic [31:0] y,
                                    input logic bw, output logic [31:0] r,
                                    output logic c, output logic v);
        longint u, s;
        u = longint'(x) - longint'(y) - longint'(bw);
        s = longint'($signed(x)) - longint'($signed(y)) - longint'(bw);
        r = u[31:0];
        c = (u >= 0);
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    // Expected outputs computed from the requirements.
    function automatic exp_t model(input stim_t s, input string tag);
        exp_t e;
        logic [31:0] b, r;
        logic sc, c, v, cf;
        cf = s.fin[1];
        if (s.ui) ref_shift({24'b0, s.i8}, 2'd3, {3'b0, s.rot, 1'b0}, cf, b, sc);
        else      ref_shift(s.rm, s.sk, s.sbr ? s.rs[7:0] : {3'b0, s.si}, cf, b, sc);
        c = sc;
        v = s.fin[0];
        case (s.op)
            4'd0:        r = b;
            4'd1:        r = ~b;
            4'd2, 4'd14: r = s.rn & b;
            4'd3:        r = s.rn | b;
            4'd4, 4'd15: r = s.rn ^ b;
            4'd5:        r = s.rn & ~b;
            4'd6, 4'd13: ref_add(s.rn, b, 1'b0, r, c, v);
            4'd7:        ref_add(s.rn, b, cf, r, c, v);
            4'd8, 4'd12: ref_sub(s.rn, b, 1'b0, r, c, v);
            4'd9:        ref_sub(s.rn, b, !cf, r, c, v);
            4'd10:       ref_sub(b, s.rn, 1'b0, r, c, v);
            default:     ref_sub(b, s.rn, !cf, r, c, v);
        endcase
        e.tag = tag;
        e.res = r;
        e.we  = (s.op[3:2] != 2'b11);
        e.fl  = (s.sf || !e.we) ? {r[31], (r == 32'd0), c, v} : s.fin;
        return e;
    endfunction

    function automatic stim_t mk_reg(input logic [3:0] op, input logic sf,
                                     input logic [31:0] rn, input logic [31:0] rm,
                                     input logic [1:0] sk, input logic [4:0] si,
                                     input logic [3:0] fin);
        stim_t s;
        s = '{op: op, sf: sf, rn: rn, ui: 1'b0, i8: 8'h00, rot: 4'h0, rm: rm,
              sk: sk, sbr: 1'b0, si: si, rs: 32'h0, fin: fin};
        return s;
    endfunction

    function automatic stim_t mk_rreg(input logic [3:0] op, input logic sf,
                                      input logic [31:0] rn, input logic [31:0] rm,
                                      input logic [1:0] sk, input logic [31:0] rs,
                                      input logic [3:0] fin);
        stim_t s;
        s = mk_reg(op, sf, rn, rm, sk, 5'd0, fin);
        s.sbr = 1'b1;
        s.rs  = rs;
        return s;
    endfunction

    function automatic stim_t mk_imm(input logic [3:0] op, input logic sf,
                                     input logic [31:0] rn, input logic [7:0] i8,
                                     input logic [3:0] rot, input logic [3:0] fin);
        stim_t s;
        s = mk_reg(op, sf, rn, 32'hDEAD_BEEF, 2'd1, 5'd7, fin);
        s.ui  = 1'b1;
        s.i8  = i8;
        s.rot = rot;
        return s;
    endfunction

    // Driver: apply a vector after the falling edge and queue its expectation.
    task automatic drive(input stim_t s, input string tag);
        @(negedge clk);
        op_code = s.op;   set_flags = s.sf;  rn_val = s.rn;   use_imm = s.ui;
        imm8 = s.i8;      imm_rot = s.rot;   rm_val = s.rm;   shift_kind = s.sk;
        shift_by_reg = s.sbr; shift_imm = s.si; rs_val = s.rs; flags_in = s.fin;
        sb_q.push_back(model(s, tag));
    endtask

    // Monitor: compare one queued expectation on each rising edge.
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (rd_we !== e.we || flags_out !== e.fl || (e.we && result !== e.res)) begin
                n_fail++;
                $display("FAIL %s: result=%h we=%b flags=%b expected result=%h we=%b flags=%b",
                         e.tag, result, rd_we, flags_out, e.res, e.we, e.fl);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        op_code = 4'd0; set_flags = 1'b0; rn_val = '0; use_imm = 1'b0; imm8 = '0;
        imm_rot = '0; rm_val = '0; shift_kind = '0; shift_by_reg = 1'b0;
        shift_imm = '0; rs_val = '0; flags_in = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // quiet vector: all zeros with held flags
        drive(mk_reg(4'd0, 1'b0, 32'h0, 32'h0, 2'd0, 5'd0, 4'b1010), "R5");
        // R1 arithmetic
        drive(mk_reg(4'd6, 1'b1, 32'hFFFF_FFFF, 32'h1, 2'd0, 5'd0, 4'b0000), "R1");
        drive(mk_reg(4'd6, 1'b1, 32'h7FFF_FFFF, 32'h1, 2'd0, 5'd0, 4'b0000), "R11");
        drive(mk_reg(4'd7, 1'b1, 32'h10, 32'h20, 2'd0, 5'd0, 4'b0010), "R1");
        drive(mk_reg(4'd8, 1'b1, 32'h5, 32'h7, 2'd0, 5'd0, 4'b0000), "R11");
        drive(mk_reg(4'd9, 1'b1, 32'h9, 32'h4, 2'd0, 5'd0, 4'b0000), "R1");
        drive(mk_reg(4'd10, 1'b1, 32'h3, 32'h40, 2'd0, 5'd0, 4'b0000), "R1");
        drive(mk_reg(4'd11, 1'b1, 32'h3, 32'h40, 2'd0, 5'd0, 4'b0010), "R1");
        drive(mk_reg(4'd8, 1'b1, 32'h8000_0000, 32'h1, 2'd0, 5'd0, 4'b0000), "R11");
        // R2 logic
        drive(mk_reg(4'd2, 1'b0, 32'hF0F0_1234, 32'hFF00_FF00, 2'd0, 5'd0, 4'b0000), "R2");
        drive(mk_reg(4'd3, 1'b0, 32'hF0F0_1234, 32'h0F00_0001, 2'd0, 5'd0, 4'b0000), "R2");
        drive(mk_reg(4'd4, 1'b0, 32'hAAAA_5555, 32'hFFFF_0000, 2'd0, 5'd0, 4'b0000), "R2");
        drive(mk_reg(4'd5, 1'b0, 32'hFFFF_FFFF, 32'h0000_FF0F, 2'd0, 5'd0, 4'b0000), "R2");
        // R3 moves ignore first operand
        drive(mk_reg(4'd0, 1'b0, 32'h1234_5678, 32'hCAFE_0001, 2'd0, 5'd0, 4'b0000), "R3");
        drive(mk_reg(4'd0, 1'b0, 32'hFFFF_FFFF, 32'hCAFE_0001, 2'd0, 5'd0, 4'b0000), "R3");
        drive(mk_reg(4'd1, 1'b0, 32'h0BAD_0BAD, 32'h0000_00FF, 2'd0, 5'd0, 4'b0000), "R3");
        // R4 compare/test: no write, flags update without set_flags
        drive(mk_reg(4'd12, 1'b0, 32'h55, 32'h55, 2'd0, 5'd0, 4'b0000), "R4");
        drive(mk_reg(4'd13, 1'b0, 32'hFFFF_FFFF, 32'h2, 2'd0, 5'd0, 4'b0000), "R4");
        drive(mk_reg(4'd14, 1'b0, 32'hF0, 32'h0F, 2'd0, 5'd0, 4'b0011), "R4");
        drive(mk_reg(4'd15, 1'b0, 32'h8000_0001, 32'h1, 2'd0, 5'd0, 4'b0001), "R4");
        // R5 arithmetic without set_flags holds flags
        drive(mk_reg(4'd8, 1'b0, 32'h0, 32'h1, 2'd0, 5'd0, 4'b0101), "R5");
        // R6 rotated constant
        drive(mk_imm(4'd0, 1'b1, 32'h0, 8'hFF, 4'd4, 4'b0000), "R6");
        drive(mk_imm(4'd0, 1'b1, 32'h0, 8'h3F, 4'd1, 4'b0000), "R6");
        drive(mk_imm(4'd0, 1'b1, 32'h0, 8'h81, 4'd0, 4'b0010), "R6");
        drive(mk_imm(4'd6, 1'b1, 32'h100, 8'h01, 4'd15, 4'b0000), "R6");
        // R7 immediate shift amounts
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h9000_000F, 2'd0, 5'd4, 4'b0000), "R7");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h9000_0018, 2'd1, 5'd4, 4'b0000), "R7");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h8000_0008, 2'd2, 5'd4, 4'b0000), "R7");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h1234_5680, 2'd3, 5'd8, 4'b0000), "R7");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h0000_0001, 2'd0, 5'd31, 4'b0000), "R7");
        // R8 register amounts at and beyond the width
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h0000_0001, 2'd0, 32'h20, 4'b0000), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'hFFFF_FFFF, 2'd0, 32'h21, 4'b0010), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h8000_0000, 2'd1, 32'h20, 4'b0000), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'hFFFF_FFFF, 2'd1, 32'hFF, 4'b0010), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h8000_1234, 2'd2, 32'h40, 4'b0000), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h7FFF_1234, 2'd2, 32'h20, 4'b0010), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h8765_4321, 2'd3, 32'h20, 4'b0000), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h8765_4321, 2'd3, 32'h28, 4'b0000), "R8");
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h0000_0003, 2'd1, 32'hFFFF_FF01, 4'b0000), "R8");
        // R9 zero amounts keep operand and incoming carry
        drive(mk_rreg(4'd0, 1'b1, 32'h0, 32'h8000_0001, 2'd1, 32'h100, 4'b0010), "R9");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h8000_0001, 2'd3, 5'd0, 4'b0000), "R9");
        drive(mk_reg(4'd0, 1'b1, 32'h0, 32'h8000_0001, 2'd2, 5'd0, 4'b0010), "R9");
        // R10 logical flags: shifter carry, V kept
        drive(mk_reg(4'd2, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 2'd0, 5'd1, 4'b0001), "R10");
        drive(mk_reg(4'd3, 1'b1, 32'h0, 32'h0000_0003, 2'd1, 5'd1, 4'b0000), "R10");
        drive(mk_reg(4'd1, 1'b1, 32'h0, 32'h0, 2'd0, 5'd0, 4'b0011), "R10");

        // mixed vectors from a fixed seed
        for (int i = 0; i < 400; i++) begin
            stim_t s;
            s.op  = 4'($urandom(i + 7) % 16);
            s.op  = 4'($urandom % 16);
            s.sf  = 1'($urandom % 2);
            s.rn  = $urandom;
            s.ui  = 1'($urandom % 3 == 0);
            s.i8  = 8'($urandom);
            s.rot = 4'($urandom);
            s.rm  = $urandom;
            s.sk  = 2'($urandom);
            s.sbr = 1'($urandom % 2);
            s.si  = 5'($urandom);
            s.rs  = {24'($urandom), 8'($urandom % 72)};
            s.fin = 4'($urandom);
            drive(s, "R11");
        end

        @(negedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule